// File: doc/BRIEF.md
# Peripheral and Memory Security Firewall

This block guards a group of bus peripherals and two on-chip memories. It holds a 2-bit access attribute for each securable peripheral, a write-once lock for each of those attributes, and, for each memory zone, a secure-region size in 4 KiB pages together with a write-once lock. All of this is programmed through an APB-style register port, and only secure accesses reach it.

Two combinational check ports apply the stored settings. The peripheral check takes a peripheral number, the security and direction of the access, and whether the coprocessor issued it. It returns allow or deny. The memory check takes an address and its security attribute. Each zone is split at a page boundary: the low part, starting at the zone base, is secure-only, and the high part is open to non-secure masters.

The bus fabric uses these verdicts to block traffic. Boot firmware writes the attributes and the zone sizes, then locks the ones that must not change for the rest of the session.

Top module: `sec_firewall`

## Requirements
- R1: After reset every peripheral attribute reads 0, every lock bit reads 0, and every zone size reads 0.
- R2: Attribute registers start at byte offset 0x010 and hold sixteen 2-bit fields per 32-bit word. Peripheral n occupies bits [2*(n%16)+1 : 2*(n%16)] of word n/16. Fields with no peripheral behind them read as 0.
- R3: Peripheral check by attribute value. Value 0 allows secure accesses only. Value 1 allows secure accesses and non-secure reads. Value 2 allows only accesses issued by the coprocessor, and denies every access from the main processor. Value 3 allows every access.
- R4: A peripheral number at or above NUM_PERIPH is always denied.
- R5: Lock registers start at offset 0x030. Peripheral n maps to bit n%32 of lock word n/32. Writing a 1 sets that lock, writing a 0 has no effect, and a set lock is never cleared except by reset.
- R6: A write to an attribute word leaves the fields of locked peripherals unchanged, while the unlocked fields in the same word still take the written value.
- R7: Zone z has a register at offset 4*z. Bits [9:0] hold the size in pages and bit 31 is a sticky lock. Once the lock is set, the size field no longer changes.
- R8: A secure memory access is always allowed. A non-secure access to an address inside zone z is denied when the address is below base + size*4 KiB, and allowed when it is at or above that point. A size larger than the zone span makes the whole zone secure. Addresses outside every zone are allowed.
- R9: Register writes marked non-secure change no state, and register reads marked non-secure return 0.
- R10: The read-only word at 0x3F0 reports the zone count in [7:0], the peripheral count in [15:8], the bus-master zone count in [23:16] and the chunk count in [31:24]. The read-only word at 0x3F4 returns VERSION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| pns | input | 1 | 1 = register access is non-secure |
| paddr | input | 12 | Register byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational) |
| per_id | input | ID_W | Peripheral number under check |
| per_ns | input | 1 | Checked access is non-secure |
| per_write | input | 1 | Checked access is a write |
| per_coproc | input | 1 | Checked access comes from the coprocessor |
| per_allow | output | 1 | Peripheral access allowed |
| mem_addr | input | ADDR_W | Memory address under check |
| mem_ns | input | 1 | Memory access is non-secure |
| mem_allow | output | 1 | Memory access allowed |

## Verification
The hardest case to reach from the ports is a locked field sitting next to unlocked fields in the same attribute word. The stimulus locks a single peripheral inside a word that is already populated, then rewrites the whole word with zeros. It reads the word back and expects only the locked field to survive.

The last peripheral slot, in a partly filled word, gets the same treatment through a second lock word. This also shows that unused fields read as zero. Zone sizes are driven past the zone span to reach the fully secure zone, and both edges of each secure/non-secure split are probed at the page boundary.

// File: rtl/sec_firewall.sv
module sec_firewall #(
  parameter int NUM_PERIPH      = 40,
  parameter int NUM_ZONE        = 2,
  parameter int NUM_BUS_MASTERS = 3,
  parameter int NUM_CHUNKS      = 0,
  parameter int ADDR_W          = 32,
  parameter int SIZE_W          = 10,
  parameter int PAGE_BITS       = 12,
  parameter int ID_W            = 8,
  parameter logic [31:0] VERSION = 32'h0000_0020,
  parameter logic [NUM_ZONE*ADDR_W-1:0] ZONE_BASE  = {32'h2000_0000, 32'h0000_0000},
  parameter logic [NUM_ZONE*SIZE_W-1:0] ZONE_PAGES = {10'd64, 10'd32}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              pns,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [ID_W-1:0]   per_id,
  input  logic              per_ns,
  input  logic              per_write,
  input  logic              per_coproc,
  output logic              per_allow,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ns,
  output logic              mem_allow
);

  localparam int ATTR_WORDS = (NUM_PERIPH + 15) / 16;
  localparam int LOCK_WORDS = (NUM_PERIPH + 31) / 32;
  localparam int ATTR_IDX   = 4;
  localparam int LOCK_IDX   = 12;
  localparam int CFG_IDX    = 252;
  localparam int VER_IDX    = 253;

  logic [NUM_PERIPH-1:0][1:0]       attr_q;
  logic [NUM_PERIPH-1:0]            lock_q;
  logic [NUM_ZONE-1:0][SIZE_W-1:0]  zsize;
  logic [NUM_ZONE-1:0]              zlock;

  logic [9:0] idx;
  logic       wr_en;
  assign idx   = paddr[11:2];
  assign wr_en = psel & penable & pwrite & ~pns;

  logic unused_bits;
  assign unused_bits = ^paddr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      lock_q <= '0;
      zsize  <= '0;
      zlock  <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NUM_PERIPH; n++) begin
        if (idx == 10'(ATTR_IDX + n / 16) && !lock_q[n])
          attr_q[n] <= pwdata[2*(n%16) +: 2];
        if (idx == 10'(LOCK_IDX + n / 32) && pwdata[n%32])
          lock_q[n] <= 1'b1;
      end
      for (int z = 0; z < NUM_ZONE; z++) begin
        if (idx == 10'(z)) begin
          if (!zlock[z]) zsize[z] <= pwdata[SIZE_W-1:0];
          if (pwdata[31]) zlock[z] <= 1'b1;
        end
      end
    end
  end

  logic [ATTR_WORDS*16-1:0][1:0] attr_pad;
  logic [LOCK_WORDS*32-1:0]      lock_pad;
  logic [31:0]                   rd;

  always_comb begin
    attr_pad = '0;
    attr_pad[NUM_PERIPH-1:0] = attr_q;
    lock_pad = '0;
    lock_pad[NUM_PERIPH-1:0] = lock_q;
    rd = '0;
    for (int z = 0; z < NUM_ZONE; z++)
      if (idx == 10'(z)) rd = {zlock[z], {(31-SIZE_W){1'b0}}, zsize[z]};
    for (int w = 0; w < ATTR_WORDS; w++)
      if (idx == 10'(ATTR_IDX + w)) rd = attr_pad[w*16 +: 16];
    for (int w = 0; w < LOCK_WORDS; w++)
      if (idx == 10'(LOCK_IDX + w)) rd = lock_pad[w*32 +: 32];
    if (idx == 10'(CFG_IDX))
      rd = {8'(NUM_CHUNKS), 8'(NUM_BUS_MASTERS), 8'(NUM_PERIPH), 8'(NUM_ZONE)};
    if (idx == 10'(VER_IDX)) rd = VERSION;
  end

  assign prdata = pns ? 32'h0 : rd;

  logic       id_ok;
  logic [1:0] sel_attr;
  logic       attr_ok;

  always_comb begin
    id_ok    = 1'b0;
    sel_attr = 2'd0;
    for (int n = 0; n < NUM_PERIPH; n++)
      if (per_id == ID_W'(n)) begin
        id_ok    = 1'b1;
        sel_attr = attr_q[n];
      end
    case (sel_attr)
      2'd0:    attr_ok = !per_ns;
      2'd1:    attr_ok = !per_ns || !per_write;
      2'd2:    attr_ok = per_coproc;
      default: attr_ok = 1'b1;
    endcase
  end

  assign per_allow = id_ok & attr_ok;

  logic [NUM_ZONE-1:0] ns_block;
  logic [ADDR_W:0]     addr_x;
  assign addr_x = {1'b0, mem_addr};

  for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
    localparam logic [ADDR_W:0] BASE = {1'b0, ZONE_BASE[z*ADDR_W +: ADDR_W]};
    localparam logic [ADDR_W:0] LIMIT =
      BASE + ((ADDR_W+1)'(ZONE_PAGES[z*SIZE_W +: SIZE_W]) << PAGE_BITS);
    logic [ADDR_W:0] sec_end;
    assign sec_end     = BASE + ((ADDR_W+1)'(zsize[z]) << PAGE_BITS);
    assign ns_block[z] = (addr_x >= BASE) && (addr_x < LIMIT) && (addr_x < sec_end);

    p_zone_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      zlock[z] |=> $stable(zsize[z]));
  end

  assign mem_allow = !mem_ns || (ns_block == '0);

  for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_chk
    p_locked_attr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[n] |=> $stable(attr_q[n]));
  end

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) & ~lock_q) == '0);

  p_ns_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && pns) |=>
      ($stable(attr_q) && $stable(lock_q) && $stable(zsize) && $stable(zlock)));

  p_ns_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pns |-> (prdata == 32'h0));

  p_oor_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_id >= ID_W'(NUM_PERIPH)) |-> !per_allow);

  p_secure_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ns |-> mem_allow);

endmodule

// File: tb/test_sec_firewall.sv
module test_sec_firewall;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0, pns = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  per_id = '0;
  logic        per_ns = 0, per_write = 0, per_coproc = 0;
  logic        per_allow;
  logic [31:0] mem_addr = '0;
  logic        mem_ns = 0;
  logic        mem_allow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sec_firewall i_sec_firewall (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pns(pns), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .per_id(per_id), .per_ns(per_ns), .per_write(per_write), .per_coproc(per_coproc),
    .per_allow(per_allow), .mem_addr(mem_addr), .mem_ns(mem_ns), .mem_allow(mem_allow)
  );

  // {id[7:0], ns, write, coproc, expected allow}
  localparam logic [11:0] VEC [18] = '{
    {8'd0,   1'b0, 1'b0, 1'b0, 1'b1},
    {8'd0,   1'b0, 1'b1, 1'b0, 1'b1},
    {8'd0,   1'b1, 1'b0, 1'b0, 1'b0},
    {8'd0,   1'b1, 1'b1, 1'b0, 1'b0},
    {8'd1,   1'b0, 1'b1, 1'b0, 1'b1},
    {8'd1,   1'b1, 1'b0, 1'b0, 1'b1},
    {8'd1,   1'b1, 1'b1, 1'b0, 1'b0},
    {8'd2,   1'b0, 1'b0, 1'b0, 1'b0},
    {8'd2,   1'b0, 1'b0, 1'b1, 1'b1},
    {8'd2,   1'b1, 1'b1, 1'b1, 1'b1},
    {8'd3,   1'b1, 1'b1, 1'b0, 1'b1},
    {8'd3,   1'b1, 1'b0, 1'b0, 1'b1},
    {8'd17,  1'b1, 1'b1, 1'b0, 1'b1},
    {8'd16,  1'b1, 1'b0, 1'b0, 1'b0},
    {8'd39,  1'b1, 1'b1, 1'b0, 1'b1},
    {8'd38,  1'b1, 1'b0, 1'b0, 1'b1},
    {8'd40,  1'b0, 1'b0, 1'b0, 1'b0},
    {8'd255, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pns = ns;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pns = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic ns, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a; pns = ns;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0; pns = 0;
  endtask

  task automatic mem_chk(input string req, input logic [31:0] a, input logic ns, input logic exp);
    @(negedge clk);
    mem_addr = a; mem_ns = ns;
    #1 check(req, 32'(mem_allow), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(12'h000, 0, d); check("R1 zone0 size", d, 32'h0);
    rd(12'h010, 0, d); check("R1 attr word0", d, 32'h0);
    rd(12'h030, 0, d); check("R1 lock word0", d, 32'h0);
    rd(12'h3F0, 0, d); check("R10 config word", d, 32'h0003_2802);
    rd(12'h3F4, 0, d); check("R10 version", d, 32'h0000_0020);

    wr(12'h010, 32'h0000_00E4, 0);
    wr(12'h014, 32'h0000_000C, 0);
    wr(12'h018, 32'hFFFF_FFFF, 0);
    rd(12'h010, 0, d); check("R2 attr word0", d, 32'h0000_00E4);
    rd(12'h014, 0, d); check("R2 attr word1 field of 17", d, 32'h0000_000C);
    rd(12'h018, 0, d); check("R2 attr word2 unused fields", d, 32'h0000_FFFF);

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      {per_id, per_ns, per_write, per_coproc} = VEC[i][11:1];
      #1 check((VEC[i][11:4] >= 8'd40) ? "R4 out of range id" : "R3 attribute check",
               32'(per_allow), 32'(VEC[i][0]));
    end

    wr(12'h030, 32'h0000_0002, 0);
    rd(12'h030, 0, d); check("R5 lock set peripheral 1", d, 32'h0000_0002);
    wr(12'h010, 32'h0000_0000, 0);
    rd(12'h010, 0, d); check("R6 locked field kept, others cleared", d, 32'h0000_0004);
    wr(12'h030, 32'h0000_0000, 0);
    rd(12'h030, 0, d); check("R5 zero write keeps lock", d, 32'h0000_0002);
    wr(12'h034, 32'h0000_0080, 0);
    rd(12'h034, 0, d); check("R5 lock word1 peripheral 39", d, 32'h0000_0080);
    wr(12'h018, 32'h0000_0000, 0);
    rd(12'h018, 0, d); check("R6 peripheral 39 kept", d, 32'h0000_C000);

    wr(12'h014, 32'h0000_0000, 1);
    rd(12'h014, 0, d); check("R9 ns write ignored", d, 32'h0000_000C);
    rd(12'h014, 1, d); check("R9 ns read zero", d, 32'h0);
    wr(12'h030, 32'h0000_0001, 1);
    rd(12'h030, 0, d); check("R9 ns lock write ignored", d, 32'h0000_0002);

    mem_chk("R8 reset size ns allowed", 32'h0000_0000, 1, 1);
    wr(12'h000, 32'h0000_0004, 0);
    rd(12'h000, 0, d); check("R7 zone0 size", d, 32'h0000_0004);
    mem_chk("R8 below split ns", 32'h0000_3FFC, 1, 0);
    mem_chk("R8 at split ns", 32'h0000_4000, 1, 1);
    mem_chk("R8 secure below split", 32'h0000_3FFC, 0, 1);
    mem_chk("R8 outside zones", 32'h0002_0000, 1, 1);
    wr(12'h004, 32'h8000_0010, 0);
    rd(12'h004, 0, d); check("R7 zone1 lock and size", d, 32'h8000_0010);
    wr(12'h004, 32'h0000_0003, 0);
    rd(12'h004, 0, d); check("R7 locked size unchanged", d, 32'h8000_0010);
    mem_chk("R8 zone1 below split", 32'h2000_FFFC, 1, 0);
    mem_chk("R8 zone1 at split", 32'h2001_0000, 1, 1);
    wr(12'h000, 32'h0000_07FF, 0);
    rd(12'h000, 0, d); check("R7 size field 10 bits", d, 32'h0000_03FF);
    mem_chk("R8 oversize zone fully secure", 32'h0001_FFFC, 1, 0);
    mem_chk("R8 just past oversized zone", 32'h0002_0000, 1, 1);

    finish_run();
  end
endmodule